// File: doc/BRIEF.md
# UART Receive Status Flags

This block sits behind the bit-level receiver of a UART. It keeps the receive status flags and the receive data register. The flags are: data ready, idle line, overrun, noise, framing or break error, and parity error. The shifter sends a single-cycle `word_done` strobe with the byte and that word's error strobes. It sends a separate `idle_hit` strobe when the line goes quiet. The block decides which flags change and whether to keep or drop the byte, and it produces one interrupt request.

Software reads the flags through two read strobes. A status read takes a snapshot of the flags and arms a clear. A data read that follows clears only the flags in that snapshot. Writes never clear a flag.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset every flag is 0, `irq` is 0 and the idle detector is armed. `status` bits 5..0 are, in order: data ready, idle, overrun, noise, framing, parity.
- R2: A word is accepted when `word_done` arrives while ready is 0. On acceptance, ready is set, `rx_byte` loads `word_byte`, and noise, framing and parity are set from that word's strobes.
- R3: A word that arrives while ready is 1, with no data read in the same cycle, sets overrun. `rx_byte` keeps its old value, and the word's noise, framing and parity strobes are ignored. So a framing error on an overrun word shows only as overrun.
- R4: A data read clears ready. A word that completes in the same cycle as a data read is accepted, not overrun.
- R5: A status read followed by a data read clears the idle, overrun, noise, framing and parity flags that were set at the status read. A data read with no status read armed leaves those flags unchanged.
- R6: A flag that sets between the arming status read and the data read stays set.
- R7: `idle_hit` sets the idle flag only when a word has been accepted since the idle flag last set. Reset counts as such an acceptance.
- R8: `irq` = (`en_rx` AND (ready OR overrun)) OR (`en_idle` AND idle) OR (`en_par` AND parity). Noise and framing never drive `irq`.
- R9: The idle, overrun, noise, framing and parity flags never fall except in a cycle with a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_done | input | 1 | Strobe: a received word is complete |
| word_byte | input | DW | Received word, valid with `word_done` |
| noise_hit | input | 1 | Noise seen on the word, valid with `word_done` |
| frame_hit | input | 1 | Framing error or break, valid with `word_done` |
| parity_hit | input | 1 | Parity error, valid with `word_done` |
| idle_hit | input | 1 | Strobe: idle line detected |
| rd_status | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe |
| en_rx | input | 1 | Receive and overrun interrupt enable |
| en_idle | input | 1 | Idle interrupt enable |
| en_par | input | 1 | Parity interrupt enable |
| status | output | 6 | Flags: ready, idle, overrun, noise, framing, parity |
| rx_byte | output | DW | Held received word |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a flag that sets between the arming status read and the data read. A clean test needs a snapshot that excludes that flag. The stimulus first leaves only data ready set and reads status, so the snapshot holds no clearable flag. It then lands an overrun word before the data read and checks that overrun survives the clear while ready falls. The same-cycle word-and-read case and the idle re-arm rule are also driven one cycle at a time from the vector table.

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_done,
  input  logic [DW-1:0] word_byte,
  input  logic          noise_hit,
  input  logic          frame_hit,
  input  logic          parity_hit,
  input  logic          idle_hit,
  input  logic          rd_status,
  input  logic          rd_data,
  input  logic          en_rx,
  input  logic          en_idle,
  input  logic          en_par,
  output logic [5:0]    status,
  output logic [DW-1:0] rx_byte,
  output logic          irq
);
  logic ready, idle, ovr, noise, frame, par;
  logic armed, idle_ok;
  logic [4:0] snap;

  wire accept  = word_done & (~ready | rd_data);
  wire overrun = word_done & ready & ~rd_data;
  wire [4:0] clr = (rd_data && armed) ? snap : 5'b0;

  assign status = {ready, idle, ovr, noise, frame, par};
  assign irq = (en_rx & (ready | ovr)) | (en_idle & idle) | (en_par & par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready   <= 1'b0;
      idle    <= 1'b0;
      ovr     <= 1'b0;
      noise   <= 1'b0;
      frame   <= 1'b0;
      par     <= 1'b0;
      armed   <= 1'b0;
      idle_ok <= 1'b1;
      snap    <= '0;
      rx_byte <= '0;
    end else begin
      ready   <= accept | (ready & ~rd_data);
      idle    <= (idle  & ~clr[4]) | (idle_hit & idle_ok);
      ovr     <= (ovr   & ~clr[3]) | overrun;
      noise   <= (noise & ~clr[2]) | (accept & noise_hit);
      frame   <= (frame & ~clr[1]) | (accept & frame_hit);
      par     <= (par   & ~clr[0]) | (accept & parity_hit);
      idle_ok <= accept | (idle_ok & ~idle_hit);
      if (accept) rx_byte <= word_byte;
      if (rd_status) begin
        armed <= 1'b1;
        snap  <= status[4:0];
      end else if (rd_data) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_done,
  input logic          frame_hit,
  input logic          rd_data,
  input logic          en_rx,
  input logic          en_idle,
  input logic          en_par,
  input logic [5:0]    status,
  input logic [DW-1:0] rx_byte,
  input logic          irq
);
  assert_ovr_keeps_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && status[5] && !rd_data) |=> (status[3] && rx_byte == $past(rx_byte)));

  assert_ovr_masks_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && frame_hit && status[5] && !rd_data && !status[1]) |=> !status[1]);

  assert_read_drops_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !word_done) |=> !status[5]);

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data |=> ((status[4:0] & $past(status[4:0])) == $past(status[4:0])));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_rx && !en_idle && !en_par) |-> !irq);
endmodule

bind uart_rx_flags uart_rx_flags_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_done(word_done), .frame_hit(frame_hit),
  .rd_data(rd_data), .en_rx(en_rx), .en_idle(en_idle), .en_par(en_par),
  .status(status), .rx_byte(rx_byte), .irq(irq)
);

// File: tb/sim_uart_rx_flags.sv
module sim_uart_rx_flags;
  localparam int PERIOD = 10;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_done = 0, noise_hit = 0, frame_hit = 0, parity_hit = 0, idle_hit = 0;
  logic rd_status = 0, rd_data = 0, en_rx = 1, en_idle = 1, en_par = 1;
  logic [7:0] word_byte = 8'h00;
  logic [5:0] status;
  logic [7:0] rx_byte;
  logic irq;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_rx_flags #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_byte(word_byte),
    .noise_hit(noise_hit), .frame_hit(frame_hit), .parity_hit(parity_hit),
    .idle_hit(idle_hit), .rd_status(rd_status), .rd_data(rd_data),
    .en_rx(en_rx), .en_idle(en_idle), .en_par(en_par),
    .status(status), .rx_byte(rx_byte), .irq(irq)
  );

  // {word_done, idle, noise, frame, parity, rd_status, rd_data, byte, exp status, exp byte}
  localparam logic [28:0] VEC [NV] = '{
    {7'b1010000, 8'hA5, 6'b100100, 8'hA5}, // R2 accept with noise
    {7'b0000010, 8'h00, 6'b100100, 8'hA5}, // R5 arm
    {7'b0000001, 8'h00, 6'b000000, 8'hA5}, // R5 R4 clear
    {7'b0100000, 8'h00, 6'b010000, 8'hA5}, // R7 idle
    {7'b0000010, 8'h00, 6'b010000, 8'hA5},
    {7'b0000001, 8'h00, 6'b000000, 8'hA5}, // R5
    {7'b0100000, 8'h00, 6'b000000, 8'hA5}, // R7 not re-armed
    {7'b1000100, 8'h3C, 6'b100001, 8'h3C}, // R2 parity
    {7'b0100000, 8'h00, 6'b110001, 8'h3C}, // R7 re-armed
    {7'b1001000, 8'h77, 6'b111001, 8'h3C}, // R3 overrun masks frame
    {7'b0000010, 8'h00, 6'b111001, 8'h3C},
    {7'b0000001, 8'h00, 6'b000000, 8'h3C}, // R5
    {7'b1000000, 8'h11, 6'b100000, 8'h11},
    {7'b0000010, 8'h00, 6'b100000, 8'h11}, // R6 arm, empty snapshot
    {7'b1010100, 8'h22, 6'b101000, 8'h11}, // R3 overrun ignores noise/parity
    {7'b0000001, 8'h00, 6'b001000, 8'h11}, // R6 overrun survives
    {7'b0000010, 8'h00, 6'b001000, 8'h11},
    {7'b0000001, 8'h00, 6'b000000, 8'h11},
    {7'b1000000, 8'h55, 6'b100000, 8'h55},
    {7'b1000001, 8'h66, 6'b100000, 8'h66}, // R4 same-cycle read accepts
    {7'b0100000, 8'h00, 6'b110000, 8'h66},
    {7'b0000001, 8'h00, 6'b010000, 8'h66}, // R5 unarmed read keeps idle
    {7'b0000010, 8'h00, 6'b010000, 8'h66},
    {7'b0000001, 8'h00, 6'b000000, 8'h66}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] c, input logic [7:0] b);
    @(negedge clk);
    {word_done, idle_hit, noise_hit, frame_hit, parity_hit, rd_status, rd_data} = c;
    word_byte = b;
    @(negedge clk);
    {word_done, idle_hit, noise_hit, frame_hit, parity_hit, rd_status, rd_data} = '0;
  endtask

  initial begin
    #(PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 status", {10'd0, status}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][28:22], VEC[i][21:14]);
      chk("R2-R7 status", {10'd0, status}, {10'd0, VEC[i][13:8]});
      chk("R2 R3 byte", {8'd0, rx_byte}, {8'd0, VEC[i][7:0]});
      chk("R8 irq", {15'd0, irq}, {15'd0, VEC[i][13] | VEC[i][12] | VEC[i][11] | VEC[i][8]});
    end
    en_rx = 0; en_idle = 0; en_par = 0;
    step(7'b1010100, 8'h99);
    chk("R8 all disabled", {15'd0, irq}, 16'd0);
    en_rx = 1; #1;
    chk("R8 rx enable", {15'd0, irq}, 16'd1);
    step(7'b0000001, 8'h00);
    chk("R8 parity only pending", {10'd0, status}, 16'b000101);
    chk("R8 noise no irq", {15'd0, irq}, 16'd0);
    en_par = 1; #1;
    chk("R8 par enable", {15'd0, irq}, 16'd1);
    en_par = 0; en_rx = 0;
    step(7'b0100000, 8'h00);
    chk("R8 idle disabled", {15'd0, irq}, 16'd0);
    en_idle = 1; #1;
    chk("R8 idle enable", {15'd0, irq}, 16'd1);
    step(7'b1001000, 8'hC3);
    chk("R2 frame on accept", {10'd0, status}, 16'b110111);
    rst_n = 1'b0; #1;
    chk("R1 async reset", {10'd0, status}, 16'd0);
    chk("R1 reset byte", {8'd0, rx_byte}, 16'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule